// File: doc/BRIEF.md
# Tick-Driven Fixed-Priority Task Scheduler

This block decides which of a small, fixed set of software tasks owns the processor. Each task has a static priority supplied on a configuration input and is at any moment in one of three conditions: holding the CPU, ready to run, or blocked. A blocked task is either sleeping for a number of scheduler ticks or waiting for its own event line. A periodic tick, normally from a hardware timer, is the only moment at which a running task can be displaced, and then only by a ready task of strictly higher priority.

The running task reports that it gives up the CPU through one of two request inputs, asking either to sleep for a count of ticks or to wait for its event. Such a request takes effect at once, and the best candidate is dispatched at the same clock edge without waiting for a tick. The block outputs the index of the task that owns the CPU, a one-cycle pulse each time a task is dispatched, and an idle flag while no task holds the CPU. Saving and restoring task context and passing messages between tasks are left to the surrounding system.

Top module: `tick_prio_sched`

## Requirements
- R1: After reset every task is ready and none holds the CPU: `idle` is 1, `ctx_sw` is 0 and `run_id` is 0.
- R2: When no task holds the CPU and at least one task is a candidate, the best candidate is dispatched at the next clock edge, tick or not.
- R3: A running task is displaced only at an edge where `tick` is 1, and only by a candidate whose priority value is strictly greater than its own (a larger value means a higher priority). An equal or lower candidate never displaces it.
- R4: Among candidates of equal priority, the one with the lower task index is chosen.
- R5: `sleep_req` blocks the running task for `sleep_ticks` ticks. The task becomes a candidate at the edge of the N-th tick after the request. A tick that arrives with the request is not counted, and a count of 0 acts as 1. If `sleep_req` and `wait_req` are both 1, the sleep request is taken.
- R6: `wait_req` blocks the running task until bit i of `event_in` is 1 for that task i. Its event bit makes a waiting task a candidate at once, but the task only displaces a running task at a later tick. An event bit is ignored for a task that is sleeping or ready.
- R7: A blocking request by the running task makes the best remaining candidate run at that same edge. If there is no candidate, the block goes idle.
- R8: `ctx_sw` is 1 for exactly one cycle, the cycle in which `run_id` first shows a newly dispatched task, and is 0 at all other times.
- R9: `idle` is 1 exactly while no task holds the CPU. During that time `run_id` keeps the last task it showed.
- R10: A task that wakes at a tick, whether its sleep count expires or its event arrives, competes in the decision taken at that same tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick | input | 1 | Scheduler tick, one cycle per period |
| task_prio | input | NTASK*PRIO_W | Static priority of each task; bits i*PRIO_W and up belong to task i; a larger value is more urgent |
| sleep_req | input | 1 | The running task asks to sleep |
| wait_req | input | 1 | The running task asks to wait for its event |
| sleep_ticks | input | CNT_W | Number of ticks to sleep, sampled with `sleep_req` |
| event_in | input | NTASK | Event lines; bit i releases task i while it waits |
| run_id | output | IW | Index of the task owning the CPU |
| idle | output | 1 | No task holds the CPU |
| ctx_sw | output | 1 | One-cycle pulse when a task is dispatched |

## Verification
The bench builds the block with four tasks, two-bit priorities and a four-bit sleep counter. The priorities are set to 1, 3, 2 and 1 for tasks 0 to 3. This gives one task that beats all others, one task in the middle, and a tie between the lowest index and the highest index. With these values a short script reaches every displacement outcome: higher, equal and lower priority at a tick. It also reaches a wake-up that preempts at its own tick, an event that arrives between ticks, a sleep request that coincides with a tick, a zero sleep count, and a period in which every task is blocked and the block goes idle.

// File: rtl/tick_prio_sched.sv
module tick_prio_sched #(
  parameter int NTASK  = 8,
  parameter int PRIO_W = 3,
  parameter int CNT_W  = 16,
  localparam int IW    = (NTASK > 1) ? $clog2(NTASK) : 1
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    tick,
  input  logic [NTASK*PRIO_W-1:0] task_prio,
  input  logic                    sleep_req,
  input  logic                    wait_req,
  input  logic [CNT_W-1:0]        sleep_ticks,
  input  logic [NTASK-1:0]        event_in,
  output logic [IW-1:0]           run_id,
  output logic                    idle,
  output logic                    ctx_sw
);

  typedef enum logic [1:0] {ST_RDY, ST_RUN, ST_SLP, ST_EVT} tstate_t;

  tstate_t          st_q  [NTASK];
  logic [CNT_W-1:0] cnt_q [NTASK];
  logic             run_v_q;
  logic [IW-1:0]    run_id_q;
  logic             ctx_q;

  logic [NTASK-1:0] wake, cand, runm;
  logic             best_v;
  logic [IW-1:0]    best_id;
  logic [PRIO_W-1:0] best_p, run_p;
  logic             blk, preempt, do_disp;
  logic [CNT_W-1:0] load_cnt;

  assign blk      = run_v_q & (sleep_req | wait_req);
  assign run_p    = task_prio[run_id_q*PRIO_W +: PRIO_W];
  assign load_cnt = (sleep_ticks == '0) ? CNT_W'(1) : sleep_ticks;

  for (genvar i = 0; i < NTASK; i++) begin : g_flags
    assign wake[i] = (st_q[i] == ST_SLP && tick && cnt_q[i] == CNT_W'(1)) ||
                     (st_q[i] == ST_EVT && event_in[i]);
    assign cand[i] = (st_q[i] == ST_RDY) || wake[i];
    assign runm[i] = (st_q[i] == ST_RUN);
  end

  always_comb begin
    best_v  = 1'b0;
    best_id = '0;
    best_p  = '0;
    for (int i = NTASK - 1; i >= 0; i--) begin
      if (cand[i] && (!best_v || task_prio[i*PRIO_W +: PRIO_W] >= best_p)) begin
        best_v  = 1'b1;
        best_id = IW'(i);
        best_p  = task_prio[i*PRIO_W +: PRIO_W];
      end
    end
  end

  assign preempt = run_v_q && !blk && tick && best_v && (best_p > run_p);
  assign do_disp = best_v && (!run_v_q || blk || preempt);

  for (genvar i = 0; i < NTASK; i++) begin : g_task
    logic is_run;
    assign is_run = run_v_q && (run_id_q == IW'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        st_q[i]  <= ST_RDY;
        cnt_q[i] <= '0;
      end else if (is_run && blk) begin
        if (sleep_req) begin
          st_q[i]  <= ST_SLP;
          cnt_q[i] <= load_cnt;
        end else begin
          st_q[i]  <= ST_EVT;
        end
      end else if (is_run && preempt) begin
        st_q[i] <= ST_RDY;
      end else if (do_disp && best_id == IW'(i)) begin
        st_q[i] <= ST_RUN;
      end else if (wake[i]) begin
        st_q[i] <= ST_RDY;
      end else if (st_q[i] == ST_SLP && tick) begin
        cnt_q[i] <= cnt_q[i] - CNT_W'(1);
      end
    end

    p_sleep_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[i] == ST_SLP && !(tick && cnt_q[i] == CNT_W'(1))) |=> st_q[i] != ST_RUN);
    p_evt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q[i] == ST_EVT && !event_in[i]) |=> st_q[i] != ST_RUN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_v_q  <= 1'b0;
      run_id_q <= '0;
      ctx_q    <= 1'b0;
    end else begin
      ctx_q <= do_disp;
      if (do_disp) begin
        run_v_q  <= 1'b1;
        run_id_q <= best_id;
      end else if (blk) begin
        run_v_q  <= 1'b0;
      end
    end
  end

  assign run_id = run_id_q;
  assign idle   = ~run_v_q;
  assign ctx_sw = ctx_q;

  p_single_owner_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(runm) == (idle ? 0 : 1));
  p_owner_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |-> runm[run_id]);
  p_tick_only_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_v_q) && !$past(tick) && !$past(blk)) |-> !ctx_sw);
  p_strict_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_v_q) && !$past(blk) && ctx_sw) |-> run_p > $past(run_p));
  p_ctx_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ctx_sw |-> !idle);

endmodule

// File: tb/tick_prio_sched_tb.sv
`timescale 1ns/100ps
module tick_prio_sched_tb_top;
  localparam int NT = 4;
  localparam int PW = 2;
  localparam int CW = 4;
  localparam int NROW = 27;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          tick = 1'b0;
  logic [NT*PW-1:0] task_prio = {2'd1, 2'd2, 2'd3, 2'd1};
  logic          sleep_req = 1'b0;
  logic          wait_req = 1'b0;
  logic [CW-1:0] sleep_ticks = '0;
  logic [NT-1:0] event_in = '0;
  logic [1:0]    run_id;
  logic          idle;
  logic          ctx_sw;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tick_prio_sched #(.NTASK(NT), .PRIO_W(PW), .CNT_W(CW)) dut_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .task_prio(task_prio),
    .sleep_req(sleep_req), .wait_req(wait_req), .sleep_ticks(sleep_ticks),
    .event_in(event_in), .run_id(run_id), .idle(idle), .ctx_sw(ctx_sw));

  // {tick, sleep, wait, ticks[3:0], events[3:0], exp_id[1:0], exp_idle, exp_ctx, req[3:0]}
  localparam logic [18:0] ROWS [NROW] = '{
    {1'b0,1'b0,1'b0,4'd0,4'b0000,2'd1,1'b0,1'b1,4'd2},  // R2 first dispatch
    {1'b0,1'b0,1'b0,4'd0,4'b0000,2'd1,1'b0,1'b0,4'd8},  // R8 pulse ends
    {1'b0,1'b1,1'b0,4'd3,4'b0000,2'd2,1'b0,1'b1,4'd7},  // R7 sleep 3
    {1'b1,1'b0,1'b0,4'd0,4'b0000,2'd2,1'b0,1'b0,4'd3},  // R3 lower ready
    {1'b0,1'b0,1'b1,4'd0,4'b0000,2'd0,1'b0,1'b1,4'd4},  // R4 tie 0 vs 3
    {1'b1,1'b0,1'b0,4'd0,4'b0000,2'd0,1'b0,1'b0,4'd3},  // R3 equal ready
    {1'b0,1'b0,1'b0,4'd0,4'b0100,2'd0,1'b0,1'b0,4'd6},  // R6 event, no tick
    {1'b1,1'b0,1'b0,4'd0,4'b0000,2'd1,1'b0,1'b1,4'd10}, // R10 wake at tick
    {1'b1,1'b0,1'b0,4'd0,4'b0000,2'd1,1'b0,1'b0,4'd3},  // R3 top holds
    {1'b0,1'b1,1'b0,4'd0,4'b0000,2'd2,1'b0,1'b1,4'd5},  // R5 zero count
    {1'b0,1'b0,1'b0,4'd0,4'b0010,2'd2,1'b0,1'b0,4'd6},  // R6 event to sleeper
    {1'b0,1'b0,1'b1,4'd0,4'b0000,2'd0,1'b0,1'b1,4'd6},  // R6 sleeper stayed
    {1'b0,1'b1,1'b0,4'd3,4'b0000,2'd3,1'b0,1'b1,4'd7},  // R7
    {1'b0,1'b0,1'b1,4'd0,4'b0000,2'd3,1'b1,1'b0,4'd9},  // R9 all blocked
    {1'b1,1'b0,1'b0,4'd0,4'b0000,2'd1,1'b0,1'b1,4'd5},  // R5 wake from idle
    {1'b0,1'b0,1'b0,4'd0,4'b1000,2'd1,1'b0,1'b0,4'd6},  // R6
    {1'b0,1'b0,1'b0,4'd0,4'b0100,2'd1,1'b0,1'b0,4'd6},  // R6
    {1'b1,1'b0,1'b0,4'd0,4'b0000,2'd1,1'b0,1'b0,4'd3},  // R3
    {1'b0,1'b0,1'b1,4'd0,4'b0000,2'd2,1'b0,1'b1,4'd7},  // R7
    {1'b1,1'b0,1'b0,4'd0,4'b0000,2'd2,1'b0,1'b0,4'd3},  // R3 woken lower
    {1'b0,1'b0,1'b0,4'd0,4'b0010,2'd2,1'b0,1'b0,4'd6},  // R6 waits for tick
    {1'b1,1'b0,1'b0,4'd0,4'b0000,2'd1,1'b0,1'b1,4'd3},  // R3 strict higher
    {1'b1,1'b1,1'b0,4'd1,4'b0000,2'd2,1'b0,1'b1,4'd5},  // R5 tick with request
    {1'b0,1'b0,1'b0,4'd0,4'b0000,2'd2,1'b0,1'b0,4'd8},  // R8
    {1'b1,1'b0,1'b0,4'd0,4'b0000,2'd1,1'b0,1'b1,4'd5},  // R5 one counted tick
    {1'b0,1'b1,1'b1,4'd1,4'b0000,2'd2,1'b0,1'b1,4'd5},  // R5 both requests
    {1'b1,1'b0,1'b0,4'd0,4'b0000,2'd1,1'b0,1'b1,4'd5}   // R5 sleep was taken
  };

  task automatic check(input string req, input logic [1:0] eid, input logic eidle, input logic ectx);
    total++;
    if (idle !== eidle || ctx_sw !== ectx || run_id !== eid) begin
      bad++;
      $display("FAIL %s: id=%0d idle=%0b ctx=%0b, expected id=%0d idle=%0b ctx=%0b",
               req, run_id, idle, ctx_sw, eid, eidle, ectx);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1", 2'd0, 1'b1, 1'b0);
    rst_n = 1'b1;
    for (int r = 0; r < NROW; r++) begin
      tick        = ROWS[r][18];
      sleep_req   = ROWS[r][17];
      wait_req    = ROWS[r][16];
      sleep_ticks = ROWS[r][15:12];
      event_in    = ROWS[r][11:8];
      @(posedge clk);
      @(negedge clk);
      check($sformatf("R%0d row %0d", ROWS[r][3:0], r), ROWS[r][7:6], ROWS[r][5], ROWS[r][4]);
      tick = 0; sleep_req = 0; wait_req = 0; sleep_ticks = '0; event_in = '0;
    end
    // R1 mid-run reset returns every task to ready
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", 2'd0, 1'b1, 1'b0);
    rst_n = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R2", 2'd1, 1'b0, 1'b1);
    wait_req = 1'b1;
    @(posedge clk); @(negedge clk);
    wait_req = 1'b0;
    check("R1", 2'd2, 1'b0, 1'b1);
    // R3 a tick with nothing higher ready keeps the owner
    tick = 1'b1;
    @(posedge clk); @(negedge clk);
    tick = 1'b0;
    check("R3", 2'd2, 1'b0, 1'b0);
    finish_run();
  end
endmodule